// File: doc/BRIEF.md
# Block-Lock Write Guard for a 2 KiB Nonvolatile Array

This block sits between a write requester and a 2048-byte nonvolatile array and decides, for every write strobe, whether the array may be written. It owns a protection control register that answers at the topmost array address. A write to that address updates the register and never reaches the array. A write to any other address goes to the array only when the protection policy allows it.

The policy has three layers. The first is a write-latch enable bit that must be set before anything nonvolatile can change. The second is a pair of region-select bits that lock none, the upper quarter, the upper half or all of the array. The third is a hardware lock formed by a register bit together with an external protect pin. When both are high, the register itself is frozen. Each request gets its verdict one clock after the strobe. A permitted write shows as a single-cycle array write pulse carrying the address and data. A refused write shows as a single-cycle refusal pulse, and neither the array nor the register changes.

Top module: `wpc_guard`

## Requirements
- R1: After reset the control register reads 00h, and both `mem_we` and `wr_blocked` are low.
- R2: While the latch-enable bit (register bit 1) is 0, a write to any address other than the top address (7FFh) is refused. The refusal raises `wr_blocked` for one cycle and `mem_we` stays low.
- R3: A write to 7FFh that the hardware lock does not refuse always loads bit 1 from data bit 1. Bit 7 and bits 4:3 are loaded from the data only if bit 1 was already 1 before that write. Otherwise they keep their values.
- R4: Register bits 4:3 pick the locked region: 00 locks nothing, 01 locks 600h–7FFh, 10 locks 400h–7FFh and 11 locks the whole array. A write into the locked region is refused as in R2.
- R5: A permitted array write raises `mem_we` for exactly one cycle, in the cycle after the strobe, with `mem_addr`/`mem_data` equal to the request, and `wr_blocked` stays low.
- R6: With `wp_pin` low, register bit 7 has no effect, and register writes proceed under R3.
- R7: With `wp_pin` high and register bit 7 set, a write to 7FFh is refused: the register is unchanged and `wr_blocked` pulses.
- R8: With `wp_pin` high and register bit 7 clear, the register stays writable under R3.
- R9: Register bits 6:5, 2 and 0 always read as zero.
- R10: A cycle without a strobe produces no `mem_we`, no `wr_blocked` and no register change, whatever `wp_pin` does.
- R11: A write to 7FFh never produces `mem_we`, whether it is accepted or refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_req | input | 1 | Write strobe, one request per cycle |
| wr_addr | input | 11 | Write byte address |
| wr_data | input | 8 | Write data |
| wp_pin | input | 1 | External hardware protect pin |
| mem_we | output | 1 | Array write permit pulse |
| mem_addr | output | 11 | Address for the permitted array write |
| mem_data | output | 8 | Data for the permitted array write |
| wr_blocked | output | 1 | One-cycle pulse marking a refused request |
| prot_reg | output | 8 | Current protection register contents |

## Verification
Two things can happen in the same cycle. A register write can set the latch-enable bit while it also carries new region and hardware-enable values, and those new values must be judged against the enable bit as it stood before that write. The bench provokes this by writing FFh and then 1Ah to 7FFh with the enable bit clear. It expects only bit 1 to change, and then checks region behaviour at the addresses on either side of 600h and 400h. A second overlap comes from the pin and the hardware-enable bit arriving together at a register write. The bench drives `wp_pin` in the same cycle as the strobe and compares the register read back on the next cycle.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

    localparam int REG_W    = 8;
    localparam int BIT_WPEN = 7;
    localparam int BIT_BPHI = 4;
    localparam int BIT_BPLO = 3;
    localparam int BIT_WEL  = 1;

    typedef enum logic [1:0] {
        BP_NONE    = 2'b00,
        BP_QUARTER = 2'b01,
        BP_HALF    = 2'b10,
        BP_ALL     = 2'b11
    } bp_e;

    typedef struct packed {
        logic wpen;
        bp_e  bp;
        logic wel;
    } prot_t;

    function automatic logic [REG_W-1:0] pack_prot(input prot_t p);
        logic [REG_W-1:0] r;
        r                   = '0;
        r[BIT_WPEN]         = p.wpen;
        r[BIT_BPHI:BIT_BPLO] = p.bp;
        r[BIT_WEL]          = p.wel;
        return r;
    endfunction

endpackage

// File: rtl/wpc_region.sv
module wpc_region
    import wpc_pkg::*;
(
    input  logic [1:0] addr_top,
    input  bp_e        bp,
    output logic       locked
);

    always_comb begin
        unique case (bp)
            BP_NONE:    locked = 1'b0;
            BP_QUARTER: locked = (addr_top == 2'b11);
            BP_HALF:    locked = addr_top[1];
            BP_ALL:     locked = 1'b1;
            default:    locked = 1'b1;
        endcase
    end

endmodule

// File: rtl/wpc_reg_policy.sv
module wpc_reg_policy
    import wpc_pkg::*;
(
    input  prot_t      cur,
    input  logic       hw_lock,
    input  logic       data_wpen,
    input  logic [1:0] data_bp,
    input  logic       data_wel,
    output prot_t      nxt,
    output logic       accept
);

    always_comb begin
        accept = !hw_lock;
        nxt    = cur;
        if (accept) begin
            nxt.wel = data_wel;
            if (cur.wel) begin
                nxt.wpen = data_wpen;
                nxt.bp   = bp_e'(data_bp);
            end
        end
    end

endmodule

// File: rtl/wpc_guard.sv
module wpc_guard
    import wpc_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wp_pin,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic              wr_blocked,
    output logic [REG_W-1:0]  prot_reg
);

    localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

    typedef struct packed {
        prot_t             prot;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              blk;
    } state_t;

    state_t state_d, state_q;

    logic  is_reg_hit;
    logic  hw_lock;
    logic  region_locked;
    logic  reg_accept;
    prot_t reg_nxt;

    assign is_reg_hit = (wr_addr == TOP_ADDR);
    assign hw_lock    = wp_pin && state_q.prot.wpen;

    wpc_region u_region (
        .addr_top (wr_addr[ADDR_W-1:ADDR_W-2]),
        .bp       (state_q.prot.bp),
        .locked   (region_locked)
    );

    wpc_reg_policy u_policy (
        .cur       (state_q.prot),
        .hw_lock   (hw_lock),
        .data_wpen (wr_data[BIT_WPEN]),
        .data_bp   (wr_data[BIT_BPHI:BIT_BPLO]),
        .data_wel  (wr_data[BIT_WEL]),
        .nxt       (reg_nxt),
        .accept    (reg_accept)
    );

    always_comb begin
        state_d      = state_q;
        state_d.we   = 1'b0;
        state_d.blk  = 1'b0;
        if (wr_req) begin
            if (is_reg_hit) begin
                state_d.prot = reg_nxt;
                state_d.blk  = !reg_accept;
            end else if (state_q.prot.wel && !region_locked) begin
                state_d.we   = 1'b1;
                state_d.addr = wr_addr;
                state_d.data = wr_data;
            end else begin
                state_d.blk  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign mem_we     = state_q.we;
    assign mem_addr   = state_q.addr;
    assign mem_data   = state_q.data;
    assign wr_blocked = state_q.blk;
    assign prot_reg   = pack_prot(state_q.prot);

    // R2: with the latch enable clear, an array write is refused
    a_r2_wel_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_req && !prot_reg[BIT_WEL] && wr_addr != TOP_ADDR) |-> (wr_blocked && !mem_we));

    // R7: pin plus hardware enable freezes the register
    a_r7_hw_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_req && is_reg_hit && wp_pin && prot_reg[BIT_WPEN]) |-> ($stable(prot_reg) && wr_blocked));

    // R9: unused register bits stay zero
    a_r9_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_reg & 8'h65) == 8'h00);

    // R10: no strobe, no effect
    a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_req) |-> (!mem_we && !wr_blocked && $stable(prot_reg)));

    // R11: register address never reaches the array
    a_r11_no_reg_we: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr != TOP_ADDR && !wr_blocked));

endmodule

// File: tb/wpc_guard_tb_top.sv
module wpc_guard_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_req = 1'b0;
    logic [10:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        wp_pin = 1'b0;
    logic        mem_we;
    logic [10:0] mem_addr;
    logic [7:0]  mem_data;
    logic        wr_blocked;
    logic [7:0]  prot_reg;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    wpc_guard dut_i (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(wr_addr),
        .wr_data(wr_data), .wp_pin(wp_pin), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_data(mem_data), .wr_blocked(wr_blocked),
        .prot_reg(prot_reg)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one request, verdict sampled at the next negedge (one register stage)
    task automatic wr(input string req, input logic [10:0] a, input logic [7:0] d,
                      input logic pin, input logic exp_we, input logic exp_blk,
                      input logic [7:0] exp_reg);
        @(negedge clk);
        wr_req = 1'b1; wr_addr = a; wr_data = d; wp_pin = pin;
        @(negedge clk);
        wr_req = 1'b0;
        chk({req, " we"},  {31'd0, mem_we},     {31'd0, exp_we});
        chk({req, " blk"}, {31'd0, wr_blocked}, {31'd0, exp_blk});
        chk({req, " reg"}, {24'd0, prot_reg},   {24'd0, exp_reg});
        if (exp_we) begin
            chk({req, " addr"}, {21'd0, mem_addr}, {21'd0, a});
            chk({req, " data"}, {24'd0, mem_data}, {24'd0, d});
        end
    endtask

    task automatic t_reset();
        chk("R1 reg", {24'd0, prot_reg}, 32'h00);
        chk("R1 we",  {31'd0, mem_we}, 32'd0);
        chk("R1 blk", {31'd0, wr_blocked}, 32'd0);
    endtask

    task automatic t_latch();
        wr("R2 array with wel=0", 11'h100, 8'h55, 1'b0, 1'b0, 1'b1, 8'h00);
        wr("R3 R9 R11 set wel only", 11'h7FF, 8'hFF, 1'b0, 1'b0, 1'b0, 8'h02);
        wr("R3 fields after wel", 11'h7FF, 8'h1A, 1'b0, 1'b0, 1'b0, 8'h1A);
    endtask

    task automatic t_regions();
        wr("R2 R4 all locked", 11'h000, 8'h11, 1'b0, 1'b0, 1'b1, 8'h1A);
        wr("R3 bp=01", 11'h7FF, 8'h0A, 1'b0, 1'b0, 1'b0, 8'h0A);
        wr("R4 R5 5FF free", 11'h5FF, 8'hA5, 1'b0, 1'b1, 1'b0, 8'h0A);
        wr("R4 600 locked", 11'h600, 8'hA6, 1'b0, 1'b0, 1'b1, 8'h0A);
        wr("R4 7FE locked", 11'h7FE, 8'hA7, 1'b0, 1'b0, 1'b1, 8'h0A);
        wr("R3 bp=10", 11'h7FF, 8'h12, 1'b0, 1'b0, 1'b0, 8'h12);
        wr("R4 R5 3FF free", 11'h3FF, 8'h3C, 1'b0, 1'b1, 1'b0, 8'h12);
        wr("R4 400 locked", 11'h400, 8'h40, 1'b0, 1'b0, 1'b1, 8'h12);
        wr("R3 bp=00", 11'h7FF, 8'h02, 1'b0, 1'b0, 1'b0, 8'h02);
        wr("R4 R5 7FE free", 11'h7FE, 8'hE7, 1'b0, 1'b1, 1'b0, 8'h02);
    endtask

    task automatic t_hw();
        wr("R6 set wpen pin low", 11'h7FF, 8'h82, 1'b0, 1'b0, 1'b0, 8'h82);
        wr("R6 rewrite pin low", 11'h7FF, 8'h8A, 1'b0, 1'b0, 1'b0, 8'h8A);
        wr("R7 R11 frozen", 11'h7FF, 8'h02, 1'b1, 1'b0, 1'b1, 8'h8A);
        wr("R4 R5 pin high array ok", 11'h010, 8'h77, 1'b1, 1'b1, 1'b0, 8'h8A);
        wr("R7 region still locked", 11'h700, 8'h70, 1'b1, 1'b0, 1'b1, 8'h8A);
        wr("R6 clear wpen", 11'h7FF, 8'h02, 1'b0, 1'b0, 1'b0, 8'h02);
        wr("R8 pin high wpen=0", 11'h7FF, 8'h12, 1'b1, 1'b0, 1'b0, 8'h12);
        wr("R3 clear all", 11'h7FF, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00);
        wr("R2 relocked", 11'h001, 8'h01, 1'b0, 1'b0, 1'b1, 8'h00);
    endtask

    task automatic t_idle();
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            wp_pin = ~wp_pin;
            wr_addr = 11'h7FF; wr_data = 8'hFF;
            @(negedge clk);
            chk("R10 idle we",  {31'd0, mem_we}, 32'd0);
            chk("R10 idle blk", {31'd0, wr_blocked}, 32'd0);
            chk("R10 idle reg", {24'd0, prot_reg}, 32'h00);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latch();
        t_regions();
        t_hw();
        t_idle();
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule